// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This unit holds the interrupt bookkeeping of a UART peripheral. Every cycle it turns the receive and transmit FIFO fill counts into a live status word. The flags are: empty, full, and at-or-above a programmable trigger level. The live flags and any error or timeout event pulses are folded into a sticky status word. Those bits stay set until software clears them by writing ones. A mask word selects which sticky bits may raise the single level-sensitive interrupt output.

Software reaches the unit through a 32-bit register port. The port has a write strobe, a 3-bit register select, write data, and combinational read data. The mask cannot be written directly. It is changed only through a set register, which ORs bits in, and a clear register, which removes bits. The receive and transmit trigger levels are kept here as writable registers. Both reset to 0x20. That value lies above any fill count a 16-entry FIFO can reach, so the trigger flags stay low until software programs a level.

Top module: `uart_irq_stat`

## Requirements
- R1: Live status is combinational from the counts and trigger levels: bit0 = rx_count >= RX trigger, bit1 = rx_count == 0, bit2 = rx_count == DEPTH (16), bit3 = tx_count == 0, bit4 = tx_count == DEPTH (16); all other bits are 0 except bit13.
- R2: The TX trigger condition (tx_count >= TX trigger) shows at live bit13 but is latched into sticky bit10; sticky bit13 is never set.
- R3: On every clock, live bits [4:0] and the TX trigger condition are ORed into the sticky word, and a sticky bit stays set after its condition goes away until it is cleared.
- R4: A write to select 3 (sticky) clears each sticky bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: One-cycle event pulses set sticky bits: RX overrun bit5, framing bit6, parity bit7, receive timeout bit8, modem status bit9, TX overflow bit12.
- R6: When a clear and a set (event pulse or live condition) hit the same sticky bit in the same cycle, the bit ends up set.
- R7: A write to select 0 ORs the write data into the mask, and a write to select 1 clears the written bits. A write to select 2 (mask) has no effect. The mask holds only implemented bits, 0x17FF.
- R8: The interrupt output is a register that is high exactly when mask AND sticky is nonzero, and it follows the register contents with no added cycle of delay.
- R9: During reset the mask and sticky words are 0, the interrupt is low, and both trigger registers read 0x20.
- R10: Read data by select: 2 mask, 3 sticky, 4 live, 5 RX trigger, 6 TX trigger; selects 0, 1 and 7 read 0. Selects 5 and 6 are writable (low 6 bits). Writes to select 4 or 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_sel |
| rx_count | input | CNT_W (5) | Receive FIFO fill count |
| tx_count | input | CNT_W (5) | Transmit FIFO fill count |
| ev_rx_overrun | input | 1 | RX overrun event pulse |
| ev_frame_err | input | 1 | Framing error event pulse |
| ev_parity_err | input | 1 | Parity error event pulse |
| ev_rx_timeout | input | 1 | Receive timeout event pulse |
| ev_modem | input | 1 | Modem status change pulse |
| ev_tx_overflow | input | 1 | TX overflow event pulse |
| live_stat | output | 32 | Live status word |
| sticky_stat | output | 32 | Sticky status word |
| mask_stat | output | 32 | Interrupt mask word |
| irq | output | 1 | Level interrupt output |

## Verification
The assertions assume that the fill counts never exceed DEPTH. They also assume that event pulses and register writes are sampled only on the rising edge, so a pulse held for one cycle is seen as exactly one event. The bench changes counts, strobes and pulses only at falling edges and keeps both counts within 0 to 16. It lines up clear writes with pulses or persisting live conditions on purpose, so that the set-over-clear rule is exercised.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int unsigned WORD_W = 32;

    // live status positions
    localparam int unsigned B_RX_TRIG      = 0;
    localparam int unsigned B_RX_EMPTY     = 1;
    localparam int unsigned B_RX_FULL      = 2;
    localparam int unsigned B_TX_EMPTY     = 3;
    localparam int unsigned B_TX_FULL      = 4;
    localparam int unsigned B_TX_TRIG_LIVE = 13;

    // sticky-only positions
    localparam int unsigned B_RX_OVR       = 5;
    localparam int unsigned B_FRAME        = 6;
    localparam int unsigned B_PARITY       = 7;
    localparam int unsigned B_TIMEOUT      = 8;
    localparam int unsigned B_MODEM        = 9;
    localparam int unsigned B_TX_TRIG_STK  = 10;
    localparam int unsigned B_TX_OVF       = 12;

    localparam logic [WORD_W-1:0] IMPL_BITS = 32'h0000_17FF;

    typedef enum logic [2:0] {
        SEL_MASK_SET = 3'd0,
        SEL_MASK_CLR = 3'd1,
        SEL_MASK     = 3'd2,
        SEL_STICKY   = 3'd3,
        SEL_LIVE     = 3'd4,
        SEL_RX_TRIG  = 3'd5,
        SEL_TX_TRIG  = 3'd6,
        SEL_NONE     = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic tx_ovf;
        logic modem;
        logic timeout;
        logic parity;
        logic frame;
        logic rx_ovr;
    } evt_t;

endpackage

// File: rtl/uart_irq_live.sv
module uart_irq_live
    import uart_irq_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned CNT_W  = $clog2(DEPTH + 1),
    parameter int unsigned TRIG_W = 6
) (
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [TRIG_W-1:0] rx_trig,
    input  logic [TRIG_W-1:0] tx_trig,
    output logic [WORD_W-1:0] live
);

    localparam int unsigned CMP_W = ((CNT_W > TRIG_W) ? CNT_W : TRIG_W) + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CMP_W-1:0] rx_ext, tx_ext, rx_trig_ext, tx_trig_ext;

    always_comb begin
        rx_ext      = CMP_W'(rx_count);
        tx_ext      = CMP_W'(tx_count);
        rx_trig_ext = CMP_W'(rx_trig);
        tx_trig_ext = CMP_W'(tx_trig);

        live                 = '0;
        live[B_RX_TRIG]      = (rx_ext >= rx_trig_ext);
        live[B_RX_EMPTY]     = (rx_count == '0);
        live[B_RX_FULL]      = (rx_count == FULL_CNT);
        live[B_TX_EMPTY]     = (tx_count == '0);
        live[B_TX_FULL]      = (tx_count == FULL_CNT);
        live[B_TX_TRIG_LIVE] = (tx_ext >= tx_trig_ext);
    end

endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uart_irq_pkg::*;
#(
    parameter int unsigned TRIG_W   = 6,
    parameter int unsigned TRIG_RST = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] live,
    input  evt_t              evt,
    output logic [WORD_W-1:0] mask_q_o,
    output logic [WORD_W-1:0] sticky_q_o,
    output logic [TRIG_W-1:0] rx_trig_q_o,
    output logic [TRIG_W-1:0] tx_trig_q_o,
    output logic              irq_q_o
);

    localparam logic [TRIG_W-1:0] TRIG_INIT = TRIG_W'(TRIG_RST);

    typedef struct packed {
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] sticky;
        logic [TRIG_W-1:0] rx_trig;
        logic [TRIG_W-1:0] tx_trig;
        logic              irq;
    } state_t;

    state_t            st_q, st_d;
    logic [WORD_W-1:0] clr_d;
    logic [WORD_W-1:0] set_d;

    always_comb begin
        st_d  = st_q;
        clr_d = '0;

        if (wr_en) begin
            unique case (wr_sel)
                SEL_MASK_SET: st_d.mask    = st_q.mask | (wr_data & IMPL_BITS);
                SEL_MASK_CLR: st_d.mask    = st_q.mask & ~wr_data;
                SEL_STICKY:   clr_d        = wr_data;
                SEL_RX_TRIG:  st_d.rx_trig = wr_data[TRIG_W-1:0];
                SEL_TX_TRIG:  st_d.tx_trig = wr_data[TRIG_W-1:0];
                default:      ;
            endcase
        end

        set_d                = '0;
        set_d[B_TX_FULL:0]   = live[B_TX_FULL:0];
        set_d[B_TX_TRIG_STK] = live[B_TX_TRIG_LIVE];
        set_d[B_RX_OVR]      = evt.rx_ovr;
        set_d[B_FRAME]       = evt.frame;
        set_d[B_PARITY]      = evt.parity;
        set_d[B_TIMEOUT]     = evt.timeout;
        set_d[B_MODEM]       = evt.modem;
        set_d[B_TX_OVF]      = evt.tx_ovf;

        // sets are applied after clears so a coincident set survives
        st_d.sticky = ((st_q.sticky & ~clr_d) | set_d) & IMPL_BITS;
        st_d.irq    = |(st_d.mask & st_d.sticky);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask    <= '0;
            st_q.sticky  <= '0;
            st_q.rx_trig <= TRIG_INIT;
            st_q.tx_trig <= TRIG_INIT;
            st_q.irq     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q_o    = st_q.mask;
    assign sticky_q_o  = st_q.sticky;
    assign rx_trig_q_o = st_q.rx_trig;
    assign tx_trig_q_o = st_q.tx_trig;
    assign irq_q_o     = st_q.irq;

endmodule

// File: rtl/uart_irq_rdmux.sv
module uart_irq_rdmux
    import uart_irq_pkg::*;
#(
    parameter int unsigned TRIG_W = 6
) (
    input  reg_sel_e          sel,
    input  logic [WORD_W-1:0] mask,
    input  logic [WORD_W-1:0] sticky,
    input  logic [WORD_W-1:0] live,
    input  logic [TRIG_W-1:0] rx_trig,
    input  logic [TRIG_W-1:0] tx_trig,
    output logic [WORD_W-1:0] rdata
);

    always_comb begin
        unique case (sel)
            SEL_MASK:    rdata = mask;
            SEL_STICKY:  rdata = sticky;
            SEL_LIVE:    rdata = live;
            SEL_RX_TRIG: rdata = WORD_W'(rx_trig);
            SEL_TX_TRIG: rdata = WORD_W'(tx_trig);
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_irq_stat.sv
module uart_irq_stat
    import uart_irq_pkg::*;
#(
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned CNT_W    = $clog2(DEPTH + 1),
    parameter int unsigned TRIG_W   = 6,
    parameter int unsigned TRIG_RST = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic              ev_rx_overrun,
    input  logic              ev_frame_err,
    input  logic              ev_parity_err,
    input  logic              ev_rx_timeout,
    input  logic              ev_modem,
    input  logic              ev_tx_overflow,
    output logic [31:0]       live_stat,
    output logic [31:0]       sticky_stat,
    output logic [31:0]       mask_stat,
    output logic              irq
);

    reg_sel_e          sel;
    evt_t              evt;
    logic [TRIG_W-1:0] rx_trig, tx_trig;

    assign sel = reg_sel_e'(reg_sel);

    always_comb begin
        evt.rx_ovr  = ev_rx_overrun;
        evt.frame   = ev_frame_err;
        evt.parity  = ev_parity_err;
        evt.timeout = ev_rx_timeout;
        evt.modem   = ev_modem;
        evt.tx_ovf  = ev_tx_overflow;
    end

    uart_irq_live #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W),
        .TRIG_W(TRIG_W)
    ) u_live (
        .rx_count(rx_count),
        .tx_count(tx_count),
        .rx_trig (rx_trig),
        .tx_trig (tx_trig),
        .live    (live_stat)
    );

    uart_irq_regs #(
        .TRIG_W  (TRIG_W),
        .TRIG_RST(TRIG_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .wr_sel     (sel),
        .wr_data    (reg_wdata),
        .live       (live_stat),
        .evt        (evt),
        .mask_q_o   (mask_stat),
        .sticky_q_o (sticky_stat),
        .rx_trig_q_o(rx_trig),
        .tx_trig_q_o(tx_trig),
        .irq_q_o    (irq)
    );

    uart_irq_rdmux #(
        .TRIG_W(TRIG_W)
    ) u_rdmux (
        .sel    (sel),
        .mask   (mask_stat),
        .sticky (sticky_stat),
        .live   (live_stat),
        .rx_trig(rx_trig),
        .tx_trig(tx_trig),
        .rdata  (reg_rdata)
    );

endmodule

// File: rtl/uart_irq_stat_chk.sv
module uart_irq_stat_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [2:0]       reg_sel,
    input logic [31:0]      reg_wdata,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] tx_count,
    input logic             ev_rx_overrun,
    input logic             ev_frame_err,
    input logic             ev_parity_err,
    input logic             ev_modem,
    input logic             ev_tx_overflow,
    input logic [31:0]      live_stat,
    input logic [31:0]      sticky_stat,
    input logic [31:0]      mask_stat,
    input logic             irq
);

    logic [31:0] clr_v;
    assign clr_v = (reg_wr && reg_sel == 3'd3) ? reg_wdata : 32'h0;

    p_live_levels_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (live_stat[1] == (rx_count == '0)) && (live_stat[2] == (rx_count == CNT_W'(DEPTH))) &&
        (live_stat[3] == (tx_count == '0)) && (live_stat[4] == (tx_count == CNT_W'(DEPTH))));

    p_tx_trig_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        live_stat[13] |=> sticky_stat[10]);

    p_no_sticky13_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sticky_stat[13]);

    p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(sticky_stat & ~clr_v) & ~sticky_stat) == 32'h0));

    p_live_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|live_stat[4:0]) |=> ((sticky_stat[4:0] & $past(live_stat[4:0])) == $past(live_stat[4:0])));

    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v[9] && !ev_modem) |=> !sticky_stat[9]);

    p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_overrun |=> sticky_stat[5]);

    p_txovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_overflow |=> sticky_stat[12]);

    p_evt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_frame_err && clr_v[6]) |=> sticky_stat[6]);

    p_mask_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 3'd2) |=> $stable(mask_stat));

    p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(mask_stat & sticky_stat)));

endmodule

bind uart_irq_stat uart_irq_stat_chk #(
    .DEPTH(DEPTH),
    .CNT_W(CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_sel       (reg_sel),
    .reg_wdata     (reg_wdata),
    .rx_count      (rx_count),
    .tx_count      (tx_count),
    .ev_rx_overrun (ev_rx_overrun),
    .ev_frame_err  (ev_frame_err),
    .ev_parity_err (ev_parity_err),
    .ev_modem      (ev_modem),
    .ev_tx_overflow(ev_tx_overflow),
    .live_stat     (live_stat),
    .sticky_stat   (sticky_stat),
    .mask_stat     (mask_stat),
    .irq           (irq)
);

// File: tb/uart_irq_stat_bench.sv
module uart_irq_stat_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [4:0]  rx_count = 5'd0;
    logic [4:0]  tx_count = 5'd0;
    logic [5:0]  ev = 6'b0;   // {txovf, modem, timeout, parity, frame, rxovr}
    logic [31:0] live_stat, sticky_stat, mask_stat;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    uart_irq_stat u_uart_irq_stat (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .rx_count      (rx_count),
        .tx_count      (tx_count),
        .ev_rx_overrun (ev[0]),
        .ev_frame_err  (ev[1]),
        .ev_parity_err (ev[2]),
        .ev_rx_timeout (ev[3]),
        .ev_modem      (ev[4]),
        .ev_tx_overflow(ev[5]),
        .live_stat     (live_stat),
        .sticky_stat   (sticky_stat),
        .mask_stat     (mask_stat),
        .irq           (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // one write cycle; returns at the falling edge after it took effect
    task automatic wr_reg(input logic [2:0] sel, input logic [31:0] data, input logic [5:0] pulse);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data; ev = pulse;
        @(negedge clk);
        reg_wr = 1'b0; ev = 6'b0;
    endtask

    task automatic pulse_ev(input logic [5:0] pulse);
        @(negedge clk);
        ev = pulse;
        @(negedge clk);
        ev = 6'b0;
    endtask

    task automatic rd_reg(input logic [2:0] sel, output logic [31:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic set_counts(input int rx, input int tx);
        @(negedge clk);
        rx_count = 5'(rx); tx_count = 5'(tx);
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        repeat (3) @(negedge clk);
        check("R9 sticky in reset", sticky_stat, 32'h0);
        check("R9 mask in reset", mask_stat, 32'h0);
        check("R9 irq in reset", {31'b0, irq}, 32'h0);
        rd_reg(3'd5, v); check("R9 rx trigger reset", v, 32'h20);
        rd_reg(3'd6, v); check("R9 tx trigger reset", v, 32'h20);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 live after reset", live_stat, 32'h0000_000A);
        check("R3 sticky latches live", sticky_stat, 32'h0000_000A);
    endtask

    task automatic t_live_levels();
        logic [31:0] v;
        set_counts(16, 16);
        check("R1 both full", live_stat, 32'h0000_0014);
        wr_reg(3'd5, 32'd4, 6'b0);
        wr_reg(3'd6, 32'd3, 6'b0);
        rd_reg(3'd5, v); check("R10 rx trigger readback", v, 32'd4);
        rd_reg(3'd6, v); check("R10 tx trigger readback", v, 32'd3);
        set_counts(4, 3);
        check("R1 R2 at trigger levels", live_stat, 32'h0000_2001);
        @(negedge clk);
        check("R2 tx trigger in sticky bit10", {31'b0, sticky_stat[10]}, 32'h1);
        check("R2 sticky bit13 clear", {31'b0, sticky_stat[13]}, 32'h0);
        set_counts(3, 2);
        check("R1 below triggers", live_stat, 32'h0);
        set_counts(2, 1);
        check("R1 neutral levels", live_stat, 32'h0);
    endtask

    task automatic t_clear();
        check("R3 sticky held after conditions end", sticky_stat, 32'h0000_041F);
        wr_reg(3'd3, 32'hFFFF_FFFF, 6'b0);
        check("R4 clear all", sticky_stat, 32'h0);
        pulse_ev(6'b000110);
        check("R5 frame and parity", sticky_stat, 32'h0000_00C0);
        wr_reg(3'd3, 32'h0000_0040, 6'b0);
        check("R4 partial clear", sticky_stat, 32'h0000_0080);
        wr_reg(3'd3, 32'h0000_0080, 6'b0);
        check("R4 clear remaining", sticky_stat, 32'h0);
    endtask

    task automatic t_events();
        int pos [6] = '{5, 6, 7, 8, 9, 12};
        for (int i = 0; i < 6; i++) begin
            pulse_ev(6'(1 << i));
            check($sformatf("R5 event %0d sets bit%0d", i, pos[i]), sticky_stat, 32'h1 << pos[i]);
            wr_reg(3'd3, 32'h1 << pos[i], 6'b0);
            check("R4 event bit cleared", sticky_stat, 32'h0);
        end
    endtask

    task automatic t_event_wins();
        wr_reg(3'd3, 32'h0000_0040, 6'b000010);
        check("R6 frame event beats clear", sticky_stat, 32'h0000_0040);
        wr_reg(3'd3, 32'h0000_0040, 6'b0);
        check("R4 frame cleared", sticky_stat, 32'h0);
        set_counts(0, 1);
        @(negedge clk);
        check("R3 rx empty latched", sticky_stat, 32'h0000_0002);
        wr_reg(3'd3, 32'h0000_0002, 6'b0);
        check("R6 live condition beats clear", sticky_stat, 32'h0000_0002);
        set_counts(2, 1);
        wr_reg(3'd3, 32'h0000_0002, 6'b0);
        check("R4 rx empty cleared", sticky_stat, 32'h0);
    endtask

    task automatic t_mask();
        wr_reg(3'd0, 32'h0000_0040, 6'b0);
        check("R7 enable sets mask", mask_stat, 32'h0000_0040);
        check("R8 irq low with no sticky", {31'b0, irq}, 32'h0);
        pulse_ev(6'b000010);
        check("R8 irq rises with frame", {31'b0, irq}, 32'h1);
        wr_reg(3'd2, 32'h0, 6'b0);
        check("R7 direct mask write ignored", mask_stat, 32'h0000_0040);
        check("R8 irq stays high", {31'b0, irq}, 32'h1);
        wr_reg(3'd1, 32'h0000_0040, 6'b0);
        check("R7 disable clears mask", mask_stat, 32'h0);
        check("R8 irq low after disable", {31'b0, irq}, 32'h0);
        wr_reg(3'd0, 32'hFFFF_FFFF, 6'b0);
        check("R7 mask keeps implemented bits", mask_stat, 32'h0000_17FF);
        check("R8 irq high again", {31'b0, irq}, 32'h1);
        wr_reg(3'd3, 32'h0000_0040, 6'b0);
        check("R8 irq low after clear", {31'b0, irq}, 32'h0);
        wr_reg(3'd1, 32'hFFFF_FFFF, 6'b0);
        check("R7 disable all", mask_stat, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        set_counts(0, 0);
        rd_reg(3'd4, v); check("R10 live readable", v, 32'h0000_000A);
        rd_reg(3'd7, v); check("R10 unused select reads 0", v, 32'h0);
        rd_reg(3'd0, v); check("R10 set register reads 0", v, 32'h0);
        wr_reg(3'd4, 32'hFFFF_FFFF, 6'b0);
        check("R10 live write ignored", live_stat, 32'h0000_000A);
        wr_reg(3'd7, 32'hFFFF_FFFF, 6'b0);
        check("R10 unused write ignored (mask)", mask_stat, 32'h0);
        rd_reg(3'd3, v); check("R10 sticky via read port", v, 32'h0000_000A);
        rd_reg(3'd5, v); check("R10 rx trigger unchanged", v, 32'd4);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_live_levels();
        t_clear();
        t_events();
        t_event_wins();
        t_mask();
        t_map();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule